// File: doc/BRIEF.md
# Base58 hash text encoder

This block turns one 256-bit binary hash into its Base58 text string. A producer offers the hash with a valid/ready handshake. The block then divides the remaining value by 58 over and over. Each remainder becomes one digit, and each digit goes through an alphabet lookup to give an ASCII character. The alphabet is "123456789ABCDEFGHJKLMNPQRSTUVWXYZabcdefghijkmnopqrstuvwxyz": it leaves out 0, O, I and l, and index 0 is '1'. Zero bytes at the top of the hash come out as leading '1' characters.

The result is a fixed 44-byte character buffer and a count of how many characters in it are valid. The consumer takes it with a second valid/ready handshake. The number of digits depends on the value, so the time to finish differs from one hash to the next. Each long division walks the value in fixed-width chunks, most significant first, and handles one chunk per cycle. The chunk width is a parameter, and an elaboration check makes sure that any chosen width still meets the worst-case cycle bound.

Top module: `b58_encoder`

## Requirements
- R1: A hash is captured only on a clock edge where in_valid and in_ready are both high. After a capture, in_ready stays low until the result has been taken (out_valid and out_ready both high). Any in_valid or in_data seen while the block is busy has no effect on the result.
- R2: The characters come from repeated division of the value by 58, keeping the remainder each time, until the quotient is zero. The most significant character is placed in byte 0 (out_chars[7:0]), and byte k sits at out_chars[8k+7:8k].
- R3: A digit d (0 to 57) becomes the character at index d of "123456789ABCDEFGHJKLMNPQRSTUVWXYZabcdefghijkmnopqrstuvwxyz".
- R4: Each zero byte at the top of the input, counted down from bits [255:248] until the first nonzero byte, adds one leading '1' (0x31) in front of the division digits.
- R5: An all-zero input gives exactly 32 '1' characters and out_len = 32.
- R6: out_len is the number of valid characters and lies between 1 and 44. Every byte at index out_len or above is 0x00.
- R7: While out_valid is high and out_ready is low, out_valid, out_chars and out_len hold steady.
- R8: out_valid rises no later than 640 clock cycles after the capture edge, for any input value.
- R9: After reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers a hash |
| in_ready | output | 1 | Block is idle and will capture a hash |
| in_data | input | 256 | Hash value, most significant byte in [255:248] |
| out_valid | output | 1 | Result is ready |
| out_ready | input | 1 | Consumer takes the result |
| out_chars | output | 352 | 44 ASCII bytes, byte 0 is the most significant character |
| out_len | output | 6 | Number of valid characters |

## Verification
A remainder or chunk index that goes wrong partway through a division shows up as a wrong character at the port. It corrupts that digit and every more significant digit, and the damage is visible when out_valid rises. The inputs 58^k and 58^k-1, swept across every k, expose errors in the length and in the loop-stop condition. A sweep of leading zero bytes exposes a wrong '1' count. A stuck state machine or a wrong loop bound shows up as out_valid arriving late or never, and the 640-cycle bound catches that.

// File: rtl/b58_pkg.sv
package b58_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHK,
      ST_DIV,
      ST_LEAD,
      ST_DONE
   } b58_state_t;

   localparam int unsigned RADIX = 58;

   // Alphabet index to ASCII, computed from the gaps left for 0, I, O and l.
   function automatic logic [7:0] b58_sym(input logic [5:0] d);
      logic [7:0] c;
      if (d < 6'd9)       c = 8'h31 + 8'(d);
      else if (d < 6'd17) c = 8'h41 + 8'(d - 6'd9);
      else if (d < 6'd22) c = 8'h4A + 8'(d - 6'd17);
      else if (d < 6'd33) c = 8'h50 + 8'(d - 6'd22);
      else if (d < 6'd44) c = 8'h61 + 8'(d - 6'd33);
      else                c = 8'h6D + 8'(d - 6'd44);
      return c;
   endfunction

endpackage

// File: rtl/b58_lead_zeros.sv
module b58_lead_zeros #(
   parameter int unsigned VAL_W = 256,
   localparam int unsigned NBYTES = VAL_W / 8,
   localparam int unsigned LZ_W = $clog2(NBYTES + 1)
) (
   input  logic [VAL_W-1:0] value,
   output logic [LZ_W-1:0]  count
);

   logic [NBYTES-1:0] zb;

   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
         assign zb[b] = (value[b*8 +: 8] == 8'h00);
      end
   endgenerate

   always_comb begin
      logic run;
      run   = 1'b1;
      count = '0;
      for (int b = NBYTES - 1; b >= 0; b--) begin
         run = run & zb[b];
         if (run) count = count + LZ_W'(1);
      end
   end

endmodule

// File: rtl/b58_div_step.sv
module b58_div_step #(
   parameter int unsigned CHUNK_W = 32
) (
   input  logic [5:0]         rem_in,
   input  logic [CHUNK_W-1:0] chunk,
   output logic [CHUNK_W-1:0] quot,
   output logic [5:0]         rem_out
);

   logic [CHUNK_W+5:0] wide;

   assign wide    = {rem_in, chunk};
   assign quot    = CHUNK_W'(wide / b58_pkg::RADIX);
   assign rem_out = 6'(wide % b58_pkg::RADIX);

endmodule

// File: rtl/b58_symbol.sv
module b58_symbol (
   input  logic [5:0] digit,
   output logic [7:0] ascii
);

   assign ascii = b58_pkg::b58_sym(digit);

endmodule

// File: rtl/b58_encoder.sv
module b58_encoder #(
   parameter int unsigned VAL_W     = 256,
   parameter int unsigned CHUNK_W   = 32,
   parameter int unsigned MAX_CHARS = 44,
   parameter int unsigned LEN_W     = 6,
   parameter int unsigned LAT_BOUND = 640
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [VAL_W-1:0]       in_data,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [MAX_CHARS*8-1:0] out_chars,
   output logic [LEN_W-1:0]       out_len
);
   import b58_pkg::*;

   localparam int unsigned NCH    = VAL_W / CHUNK_W;
   localparam int unsigned IDX_W  = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int unsigned NBYTES = VAL_W / 8;
   localparam int unsigned LZ_W   = $clog2(NBYTES + 1);
   localparam int unsigned BUF_W  = MAX_CHARS * 8;
   localparam int unsigned WORST  = MAX_CHARS * NCH + NBYTES + 4;

   generate
      if (VAL_W % CHUNK_W != 0) begin : g_bad_chunk
         $error("VAL_W must be a multiple of CHUNK_W");
      end
      if (VAL_W % 8 != 0) begin : g_bad_bytes
         $error("VAL_W must be whole bytes");
      end
      if ((1 << LEN_W) <= MAX_CHARS) begin : g_bad_len
         $error("LEN_W too narrow for MAX_CHARS");
      end
      if (WORST > LAT_BOUND) begin : g_bad_lat
         $error("CHUNK_W too narrow to meet LAT_BOUND");
      end
   endgenerate

   b58_state_t         state;
   logic [VAL_W-1:0]   val_q;
   logic [5:0]         rem_q;
   logic [IDX_W-1:0]   idx_q;
   logic               qnz_q;
   logic [LZ_W-1:0]    lz_q;
   logic [BUF_W-1:0]   buf_q;
   logic [LEN_W-1:0]   len_q;

   logic [LZ_W-1:0]    lz_in;
   logic [CHUNK_W-1:0] chunk, quot;
   logic [5:0]         rem_out, sym_digit;
   logic [7:0]         sym;
   logic               last_chunk;

   b58_lead_zeros #(.VAL_W(VAL_W)) lz_i (
      .value (in_data),
      .count (lz_in)
   );

   assign chunk = val_q[idx_q*CHUNK_W +: CHUNK_W];

   b58_div_step #(.CHUNK_W(CHUNK_W)) div_i (
      .rem_in  (rem_q),
      .chunk   (chunk),
      .quot    (quot),
      .rem_out (rem_out)
   );

   assign sym_digit = (state == ST_LEAD) ? 6'd0 : rem_out;

   b58_symbol sym_i (
      .digit (sym_digit),
      .ascii (sym)
   );

   assign last_chunk = (idx_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         val_q <= '0;
         rem_q <= '0;
         idx_q <= '0;
         qnz_q <= 1'b0;
         lz_q  <= '0;
         buf_q <= '0;
         len_q <= '0;
      end else begin
         case (state)
            ST_IDLE: if (in_valid) begin
               val_q <= in_data;
               lz_q  <= lz_in;
               buf_q <= '0;
               len_q <= '0;
               rem_q <= '0;
               idx_q <= IDX_W'(NCH - 1);
               qnz_q <= 1'b0;
               state <= ST_CHK;
            end
            ST_CHK: state <= (val_q == '0) ? ST_LEAD : ST_DIV;
            ST_DIV: begin
               val_q[idx_q*CHUNK_W +: CHUNK_W] <= quot;
               if (last_chunk) begin
                  buf_q <= {buf_q[BUF_W-9:0], sym};
                  len_q <= len_q + LEN_W'(1);
                  rem_q <= '0;
                  idx_q <= IDX_W'(NCH - 1);
                  qnz_q <= 1'b0;
                  state <= (qnz_q || quot != '0) ? ST_DIV : ST_LEAD;
               end else begin
                  rem_q <= rem_out;
                  idx_q <= idx_q - IDX_W'(1);
                  qnz_q <= qnz_q | (quot != '0);
               end
            end
            ST_LEAD: begin
               if (lz_q == '0) begin
                  state <= ST_DONE;
               end else begin
                  buf_q <= {buf_q[BUF_W-9:0], sym};
                  len_q <= len_q + LEN_W'(1);
                  lz_q  <= lz_q - LZ_W'(1);
               end
            end
            ST_DONE: if (out_ready) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign in_ready  = (state == ST_IDLE);
   assign out_valid = (state == ST_DONE);
   assign out_chars = buf_q;
   assign out_len   = len_q;

endmodule

// File: rtl/b58_encoder_chk.sv
module b58_encoder_chk #(
   parameter int unsigned MAX_CHARS = 44,
   parameter int unsigned LEN_W     = 6,
   parameter int unsigned LAT_BOUND = 640
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic                   in_ready,
   input logic                   out_valid,
   input logic                   out_ready,
   input logic [MAX_CHARS*8-1:0] out_chars,
   input logic [LEN_W-1:0]       out_len
);

   logic [15:0] busy_cnt;
   logic        tail_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       busy_cnt <= '0;
      else if (in_valid && in_ready)    busy_cnt <= 16'd1;
      else if (!in_ready && !out_valid) busy_cnt <= busy_cnt + 16'd1;
      else                              busy_cnt <= '0;
   end

   always_comb begin
      tail_ok = 1'b1;
      for (int k = 0; k < int'(MAX_CHARS); k++) begin
         if (k >= int'(out_len) && out_chars[k*8 +: 8] != 8'h00) tail_ok = 1'b0;
         if (k <  int'(out_len) && out_chars[k*8 +: 8] == 8'h00) tail_ok = 1'b0;
      end
   end

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready); // R1
   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid)); // R1
   AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_len >= LEN_W'(1) && out_len <= LEN_W'(MAX_CHARS))); // R6
   AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> tail_ok); // R6
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_chars) && $stable(out_len))); // R7
   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= 16'(LAT_BOUND)); // R8

endmodule

bind b58_encoder b58_encoder_chk #(
   .MAX_CHARS (MAX_CHARS),
   .LEN_W     (LEN_W),
   .LAT_BOUND (LAT_BOUND)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_chars (out_chars),
   .out_len   (out_len)
);

// File: tb/b58_encoder_tb_top.sv
module b58_encoder_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [255:0] in_data = '0;
   logic         out_valid;
   logic         out_ready = 1'b0;
   logic [351:0] out_chars;
   logic [5:0]   out_len;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   string alpha = "123456789ABCDEFGHJKLMNPQRSTUVWXYZabcdefghijkmnopqrstuvwxyz";

   always #5 clk = ~clk;

   b58_encoder dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_chars (out_chars),
      .out_len   (out_len)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [351:0] act, input logic [351:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic model(input logic [255:0] v, output logic [351:0] ebuf, output int elen);
      int lz;
      int n;
      logic [5:0] dig [44];
      logic [255:0] w;
      lz = 0;
      for (int b = 31; b >= 0; b--) begin
         if (v[b*8 +: 8] != 8'h00) break;
         lz++;
      end
      w = v;
      n = 0;
      while (w != 0) begin
         dig[n] = 6'(w % 256'd58);
         w = w / 256'd58;
         n++;
      end
      ebuf = '0;
      for (int i = 0; i < lz; i++) ebuf[i*8 +: 8] = 8'h31;
      for (int j = 0; j < n; j++) ebuf[(lz+j)*8 +: 8] = alpha[int'(dig[n-1-j])];
      elen = lz + n;
   endtask

   task automatic run_one(input logic [255:0] v, input string req);
      logic [351:0] ebuf;
      logic [351:0] held;
      int elen;
      int lat;
      model(v, ebuf, elen);
      @(negedge clk);
      check(in_ready == 1'b1, "R1", "ready before offer", 352'(in_ready), 352'(1));
      in_data  = v;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      lat = 1;
      while (!out_valid && lat < 2000) begin
         if (lat == 3) begin
            check(in_ready == 1'b0, "R1", "ready while busy", 352'(in_ready), 352'(0));
            in_valid = 1'b1;
            in_data  = ~v;
         end
         @(negedge clk);
         lat++;
      end
      in_valid = 1'b0;
      check(lat <= 640, "R8", "latency", 352'(lat), 352'(640));
      check(int'(out_len) == elen, req, "length", 352'(out_len), 352'(elen));
      check(out_chars == ebuf, req, "characters", out_chars, ebuf);
      held = out_chars;
      @(negedge clk);
      @(negedge clk);
      check(out_valid && out_chars == held && int'(out_len) == elen, "R7",
            "hold under backpressure", out_chars, held);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      check(!out_valid && in_ready, "R1", "release after take",
            352'({out_valid, in_ready}), 352'(2'b01));
   endtask

   initial begin
      int cyc;
      cyc = 0;
      while (!finished && cyc < 190000) begin
         @(posedge clk);
         cyc++;
      end
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [255:0] p;
      logic [255:0] lfsr;
      repeat (3) @(negedge clk);
      check(in_ready == 1'b1 && out_valid == 1'b0, "R9", "reset state",
            352'({in_ready, out_valid}), 352'(2'b10));
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1 && out_valid == 1'b0, "R9", "after reset release",
            352'({in_ready, out_valid}), 352'(2'b10));

      run_one('0, "R5");
      for (int d = 1; d < 58; d++) run_one(256'(d), "R3");
      for (int k = 0; k < 32; k++) begin
         run_one(256'h80 << (8 * (31 - k)), "R4");
         run_one(256'h01 << (8 * (31 - k)), "R4");
      end
      p = 256'd1;
      for (int k = 1; k <= 43; k++) begin
         p = p * 256'd58;
         run_one(p - 256'd1, "R2");
         run_one(p, "R2");
      end
      run_one({256{1'b1}}, "R6");
      lfsr = 256'hC0FFEE_1234_5678_9ABC_DEF0_0BAD_F00D_1357_9BDF_2468_ACE0_FEED_BEEF_CAFE_0001;
      for (int r = 0; r < 20; r++) begin
         lfsr = {lfsr[254:0], lfsr[255] ^ lfsr[253] ^ lfsr[250] ^ lfsr[245]};
         lfsr = lfsr * 256'd1103515245 + 256'd12345;
         run_one(lfsr, "R2");
         run_one(lfsr >> (r * 12), "R6");
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule